// File: doc/BRIEF.md
# Configurable Tile Register File

This block holds eight two-dimensional tile registers that feed a matrix engine. Each tile can store up to 16 rows of 64 bytes, for 8 KB in total. Before any tile can be used, a configuration word is written. It selects palette 1, the eight-tile layout, and gives every tile its own row count and bytes-per-row width. Palette 0 is the initialized state, and in that state no tile can be used.

Tile contents are read and written one whole 64-byte row per cycle. Each access is checked against the shape of the tile it targets. A row index outside the shape is refused and flagged. Bytes past the configured width are stored as zero and read back as zero. A configuration stays in force until it is rewritten or released. A release command, or a configuration write of palette 0, returns the file to its initialized state and makes every row read as zero. The current palette and the shape of every tile are driven on output ports, so a downstream engine can size its own work from them.

Top module: `tile_file`

## Requirements
- R1: After reset, `paletteId` is 0, `configured` is low, and every field of `tileRows` and `tileColsb` is 0.
- R2: A configuration write with palette 1, every row count of at most 16 and every width of at most 64 bytes is accepted. The new values appear on `paletteId`, `tileRows` and `tileColsb` on the next cycle, and `configured` goes high. Tile t's row count sits at `cfgRows[5t+4:5t]` and its width at `cfgColsb[7t+6:7t]`, and the outputs use the same packing.
- R3: A configuration write is rejected when its palette is neither 0 nor 1, when any row count is above 16, or when any width is above 64. A rejected write pulses `cfgErr` for one cycle on the next cycle and leaves the previous configuration unchanged.
- R4: A legal row write stores `accWrData` in the addressed row. A legal row read returns that row on `rdData`, with `rdValid` high, one cycle after the request.
- R5: An access whose row index is not below the tile's configured row count has no effect. One cycle later `accErr` is high, `rdValid` is low and `rdData` is zero.
- R6: Byte i of a row is carried on bits [8i+7:8i]. Bytes whose index is at or above the tile's configured width are stored and read as zero.
- R7: While the palette is 0, every access is flagged on `accErr` one cycle later and leaves no trace in tile contents.
- R8: A release, or an accepted write of palette 0, clears all shape metadata and drops `configured` on the next cycle. After that, every row reads as zero until it is written again.
- R9: If `relCmd` is asserted in the same cycle as a configuration write or an access, the release wins. The configuration write is discarded and the access is flagged on `accErr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| relCmd | input | 1 | Return the file to the initialized state |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgPalette | input | 8 | Palette selector for the configuration write |
| cfgRows | input | 40 | Row count per tile, 5 bits each |
| cfgColsb | input | 56 | Bytes per row per tile, 7 bits each |
| accEn | input | 1 | Row access request |
| accWe | input | 1 | 1 for a write, 0 for a read |
| accTile | input | 3 | Tile index |
| accRow | input | 4 | Row index within the tile |
| accWrData | input | 512 | Row data to write |
| rdData | output | 512 | Row read data, zero when no valid read |
| rdValid | output | 1 | Read data valid |
| accErr | output | 1 | Previous access was refused |
| cfgErr | output | 1 | Previous configuration write was rejected |
| configured | output | 1 | Palette 1 is active |
| paletteId | output | 8 | Current palette |
| tileRows | output | 40 | Current row count per tile |
| tileColsb | output | 56 | Current bytes per row per tile |

## Verification
Some behaviours are checked by the assertions on every cycle. A rejected configuration never moves the shape outputs. No read is ever valid unless the file was configured. An access error never comes with valid data. A release always empties the metadata. Every published shape stays within the 16-row, 64-byte limit. Other behaviours can only be shown by the bench's scenarios. These are the round trip of row data, the zeroing of bytes past a tile's width, and the fact that a refused write leaves no trace. They also include the contents reading as zero after a release or a palette-0 write, which needs a later reconfiguration and readback.

// File: rtl/tile_pkg.sv
package tile_pkg;
  parameter int NUM_TILES = 8;
  parameter int MAX_ROWS  = 16;
  parameter int ROW_BYTES = 64;
  parameter int PAL_W     = 8;

  localparam int TILE_W   = $clog2(NUM_TILES);
  localparam int RIDX_W   = $clog2(MAX_ROWS);
  localparam int ROW_W    = $clog2(MAX_ROWS + 1);
  localparam int CB_W     = $clog2(ROW_BYTES + 1);
  localparam int ROW_BITS = ROW_BYTES * 8;
  localparam int DEPTH    = NUM_TILES * MAX_ROWS;
  localparam int ADDR_W   = $clog2(DEPTH);

  localparam logic [PAL_W-1:0] PAL_INIT   = '0;
  localparam logic [PAL_W-1:0] PAL_ACTIVE = PAL_W'(1);

  typedef struct packed {
    logic              clearAll;
    logic              wrRow;
    logic              rdRow;
    logic [TILE_W-1:0] tile;
    logic [RIDX_W-1:0] row;
    logic [CB_W-1:0]   colsb;
  } tileStrobes_t;

  function automatic logic [ROW_BITS-1:0] byteMask(input logic [CB_W-1:0] n);
    logic [ROW_BITS-1:0] m;
    for (int i = 0; i < ROW_BYTES; i++) begin
      m[8*i +: 8] = (i < int'(n)) ? 8'hFF : 8'h00;
    end
    return m;
  endfunction
endpackage

// File: rtl/tile_ctrl.sv
module tile_ctrl
  import tile_pkg::*;
(
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      relCmd,
  input  logic                      cfgWrEn,
  input  logic [PAL_W-1:0]          cfgPalette,
  input  logic [NUM_TILES*ROW_W-1:0] cfgRows,
  input  logic [NUM_TILES*CB_W-1:0]  cfgColsb,
  input  logic                      accEn,
  input  logic                      accWe,
  input  logic [TILE_W-1:0]         accTile,
  input  logic [RIDX_W-1:0]         accRow,
  output tileStrobes_t              strobes,
  output logic                      accErr,
  output logic                      cfgErr,
  output logic                      configured,
  output logic [PAL_W-1:0]          paletteId,
  output logic [NUM_TILES*ROW_W-1:0] tileRows,
  output logic [NUM_TILES*CB_W-1:0]  tileColsb
);
  logic [PAL_W-1:0] paletteQ;
  logic [ROW_W-1:0] rowsQ  [NUM_TILES];
  logic [CB_W-1:0]  colsbQ [NUM_TILES];

  logic shapesOk, palZero, doClear, doLoad, cfgBad, accOk;

  always_comb begin
    shapesOk = 1'b1;
    for (int t = 0; t < NUM_TILES; t++) begin
      if (int'(cfgRows[t*ROW_W +: ROW_W]) > MAX_ROWS)   shapesOk = 1'b0;
      if (int'(cfgColsb[t*CB_W +: CB_W]) > ROW_BYTES)   shapesOk = 1'b0;
    end
  end

  assign palZero    = (cfgPalette == PAL_INIT);
  assign doClear    = relCmd | (cfgWrEn & palZero);
  assign doLoad     = !relCmd & cfgWrEn & (cfgPalette == PAL_ACTIVE) & shapesOk;
  assign cfgBad     = !relCmd & cfgWrEn & !palZero & !doLoad;
  assign configured = (paletteQ == PAL_ACTIVE);
  assign accOk      = accEn & configured & !doClear &
                      ({1'b0, accRow} < (RIDX_W+1)'(rowsQ[accTile]));

  always_comb begin
    strobes.clearAll = doClear;
    strobes.wrRow    = accOk & accWe;
    strobes.rdRow    = accOk & !accWe;
    strobes.tile     = accTile;
    strobes.row      = accRow;
    strobes.colsb    = colsbQ[accTile];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      paletteQ <= PAL_INIT;
      accErr   <= 1'b0;
      cfgErr   <= 1'b0;
      for (int t = 0; t < NUM_TILES; t++) begin
        rowsQ[t]  <= '0;
        colsbQ[t] <= '0;
      end
    end else begin
      accErr <= accEn & !accOk;
      cfgErr <= cfgBad;
      if (doClear) begin
        paletteQ <= PAL_INIT;
        for (int t = 0; t < NUM_TILES; t++) begin
          rowsQ[t]  <= '0;
          colsbQ[t] <= '0;
        end
      end else if (doLoad) begin
        paletteQ <= PAL_ACTIVE;
        for (int t = 0; t < NUM_TILES; t++) begin
          rowsQ[t]  <= cfgRows[t*ROW_W +: ROW_W];
          colsbQ[t] <= cfgColsb[t*CB_W +: CB_W];
        end
      end
    end
  end

  assign paletteId = paletteQ;

  for (genvar t = 0; t < NUM_TILES; t++) begin : g_shape
    assign tileRows[t*ROW_W +: ROW_W] = rowsQ[t];
    assign tileColsb[t*CB_W +: CB_W]  = colsbQ[t];
  end
endmodule

// File: rtl/tile_datapath.sv
module tile_datapath
  import tile_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  tileStrobes_t        strobes,
  input  logic [ROW_BITS-1:0] accWrData,
  output logic [ROW_BITS-1:0] rdData,
  output logic                rdValid
);
  logic [ROW_BITS-1:0] mem [DEPTH];
  logic [DEPTH-1:0]    rowLive;
  logic [ADDR_W-1:0]   addr;
  logic [ROW_BITS-1:0] mask;

  assign addr = ADDR_W'(int'(strobes.tile) * MAX_ROWS + int'(strobes.row));
  assign mask = byteMask(strobes.colsb);

  always_ff @(posedge clk) begin
    if (strobes.wrRow && !strobes.clearAll) begin
      mem[addr] <= accWrData & mask;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rowLive <= '0;
      rdData  <= '0;
      rdValid <= 1'b0;
    end else begin
      if (strobes.clearAll) begin
        rowLive <= '0;
      end else if (strobes.wrRow) begin
        rowLive[addr] <= 1'b1;
      end
      rdValid <= strobes.rdRow;
      if (strobes.rdRow && rowLive[addr]) begin
        rdData <= mem[addr] & mask;
      end else begin
        rdData <= '0;
      end
    end
  end
endmodule

// File: rtl/tile_file.sv
module tile_file
  import tile_pkg::*;
(
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       relCmd,
  input  logic                       cfgWrEn,
  input  logic [PAL_W-1:0]           cfgPalette,
  input  logic [NUM_TILES*ROW_W-1:0] cfgRows,
  input  logic [NUM_TILES*CB_W-1:0]  cfgColsb,
  input  logic                       accEn,
  input  logic                       accWe,
  input  logic [TILE_W-1:0]          accTile,
  input  logic [RIDX_W-1:0]          accRow,
  input  logic [ROW_BITS-1:0]        accWrData,
  output logic [ROW_BITS-1:0]        rdData,
  output logic                       rdValid,
  output logic                       accErr,
  output logic                       cfgErr,
  output logic                       configured,
  output logic [PAL_W-1:0]           paletteId,
  output logic [NUM_TILES*ROW_W-1:0] tileRows,
  output logic [NUM_TILES*CB_W-1:0]  tileColsb
);
  tileStrobes_t strobes;

  tile_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .relCmd(relCmd),
    .cfgWrEn(cfgWrEn), .cfgPalette(cfgPalette), .cfgRows(cfgRows), .cfgColsb(cfgColsb),
    .accEn(accEn), .accWe(accWe), .accTile(accTile), .accRow(accRow),
    .strobes(strobes), .accErr(accErr), .cfgErr(cfgErr), .configured(configured),
    .paletteId(paletteId), .tileRows(tileRows), .tileColsb(tileColsb)
  );

  tile_datapath u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .accWrData(accWrData), .rdData(rdData), .rdValid(rdValid)
  );
endmodule

// File: rtl/tile_file_chk.sv
module tile_file_chk
  import tile_pkg::*;
(
  input logic                       clk,
  input logic                       rstN,
  input logic                       relCmd,
  input logic                       rdValid,
  input logic                       accErr,
  input logic                       cfgErr,
  input logic                       configured,
  input logic [PAL_W-1:0]           paletteId,
  input logic [NUM_TILES*ROW_W-1:0] tileRows,
  input logic [NUM_TILES*CB_W-1:0]  tileColsb
);
  AST_REJECT_KEEPS_CFG: assert property (@(posedge clk) disable iff (!rstN)
    cfgErr |-> ($stable(tileRows) && $stable(tileColsb) && $stable(paletteId))); // R3

  AST_READ_NEEDS_CFG: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> $past(configured)); // R7

  AST_ERR_NOT_VALID: assert property (@(posedge clk) disable iff (!rstN)
    accErr |-> !rdValid); // R5

  AST_RELEASE_EMPTIES: assert property (@(posedge clk) disable iff (!rstN)
    relCmd |=> (!configured && tileRows == '0 && tileColsb == '0)); // R8

  for (genvar t = 0; t < NUM_TILES; t++) begin : g_lim
    AST_SHAPE_LIMIT: assert property (@(posedge clk) disable iff (!rstN)
      (int'(tileRows[t*ROW_W +: ROW_W]) <= MAX_ROWS &&
       int'(tileColsb[t*CB_W +: CB_W]) <= ROW_BYTES)); // R2
  end
endmodule

bind tile_file tile_file_chk u_chk (.*);

// File: tb/test_tile_file.sv
module test_tile_file;
  import tile_pkg::*;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic relCmd = 1'b0, cfgWrEn = 1'b0, accEn = 1'b0, accWe = 1'b0;
  logic [PAL_W-1:0] cfgPalette = '0;
  logic [NUM_TILES*ROW_W-1:0] cfgRows = '0;
  logic [NUM_TILES*CB_W-1:0]  cfgColsb = '0;
  logic [TILE_W-1:0] accTile = '0;
  logic [RIDX_W-1:0] accRow = '0;
  logic [ROW_BITS-1:0] accWrData = '0;
  logic [ROW_BITS-1:0] rdData;
  logic rdValid, accErr, cfgErr, configured;
  logic [PAL_W-1:0] paletteId;
  logic [NUM_TILES*ROW_W-1:0] tileRows;
  logic [NUM_TILES*CB_W-1:0]  tileColsb;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  tile_file i_tile_file (.*);

  typedef struct packed {
    logic       isRead;
    logic [2:0] tile;
    logic [3:0] row;
    logic [7:0] fill;
    logic       expErr;
    logic [7:0] expByte;
  } vecT;

  localparam int NV = 12;
  localparam vecT VEC [NV] = '{
    '{1'b0, 3'd0, 4'd0,  8'hA1, 1'b0, 8'h00},
    '{1'b1, 3'd0, 4'd0,  8'h00, 1'b0, 8'hA1},
    '{1'b0, 3'd3, 4'd9,  8'hB2, 1'b0, 8'h00},
    '{1'b1, 3'd3, 4'd9,  8'h00, 1'b0, 8'hB2},
    '{1'b0, 3'd7, 4'd2,  8'hC3, 1'b1, 8'h00},
    '{1'b1, 3'd7, 4'd2,  8'h00, 1'b1, 8'h00},
    '{1'b0, 3'd7, 4'd1,  8'hD4, 1'b0, 8'h00},
    '{1'b1, 3'd7, 4'd1,  8'h00, 1'b0, 8'hD4},
    '{1'b1, 3'd5, 4'd0,  8'h00, 1'b0, 8'h00},
    '{1'b0, 3'd0, 4'd15, 8'hE5, 1'b0, 8'h00},
    '{1'b1, 3'd0, 4'd15, 8'h00, 1'b0, 8'hE5},
    '{1'b1, 3'd1, 4'd14, 8'h00, 1'b1, 8'h00}
  };

  function automatic int shapeRows(int t);  return 16 - 2*t; endfunction
  function automatic int shapeCols(int t);  return 64 - 8*t; endfunction

  function automatic logic [ROW_BITS-1:0] expRow(logic [7:0] b, int cols);
    logic [ROW_BITS-1:0] r;
    for (int i = 0; i < ROW_BYTES; i++) r[8*i +: 8] = (i < cols) ? b : 8'h00;
    return r;
  endfunction

  function automatic logic [ROW_BITS-1:0] fillRow(logic [7:0] b);
    return {ROW_BYTES{b}};
  endfunction

  logic [NUM_TILES*ROW_W-1:0] goodRows;
  logic [NUM_TILES*CB_W-1:0]  goodCols;

  task automatic chk(string req, logic [ROW_BITS-1:0] act, logic [ROW_BITS-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic doCfg(logic [7:0] pal, logic [NUM_TILES*ROW_W-1:0] r,
                       logic [NUM_TILES*CB_W-1:0] c, logic rel);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgPalette = pal; cfgRows = r; cfgColsb = c; relCmd = rel;
    @(negedge clk);
    cfgWrEn = 1'b0; relCmd = 1'b0;
  endtask

  task automatic doAcc(logic we, int t, int r, logic [7:0] fill);
    @(negedge clk);
    accEn = 1'b1; accWe = we; accTile = TILE_W'(t); accRow = RIDX_W'(r);
    accWrData = fillRow(fill);
    @(negedge clk);
    accEn = 1'b0;
  endtask

  task automatic doRelease();
    @(negedge clk); relCmd = 1'b1;
    @(negedge clk); relCmd = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [NUM_TILES*ROW_W-1:0] badRows;
    logic [NUM_TILES*CB_W-1:0]  badCols;
    for (int t = 0; t < NUM_TILES; t++) begin
      goodRows[t*ROW_W +: ROW_W] = ROW_W'(shapeRows(t));
      goodCols[t*CB_W +: CB_W]   = CB_W'(shapeCols(t));
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 paletteId", 512'(paletteId), 512'(0));
    chk("R1 configured", 512'(configured), 512'(0));
    chk("R1 shapes", 512'({tileRows, tileColsb}), 512'(0));

    // R7 access while unconfigured
    doAcc(1'b1, 0, 0, 8'h77);
    chk("R7 write flagged", 512'(accErr), 512'(1));
    doAcc(1'b0, 0, 0, 8'h00);
    chk("R7 read flagged", 512'({accErr, rdValid}), 512'(2'b10));

    // R3 bad palette
    doCfg(8'd2, goodRows, goodCols, 1'b0);
    chk("R3 bad palette flagged", 512'(cfgErr), 512'(1));
    chk("R3 bad palette keeps init", 512'(configured), 512'(0));

    // R2 good config
    doCfg(8'd1, goodRows, goodCols, 1'b0);
    chk("R2 configured", 512'({configured, cfgErr}), 512'(2'b10));
    chk("R2 paletteId", 512'(paletteId), 512'(1));
    chk("R2 tileRows", 512'(tileRows), 512'(goodRows));
    chk("R2 tileColsb", 512'(tileColsb), 512'(goodCols));

    // R7 no trace from the unconfigured write
    doAcc(1'b0, 0, 0, 8'h00);
    chk("R7 no trace", rdData, '0);

    // R4 R5 R6 vector table
    for (int v = 0; v < NV; v++) begin
      doAcc(!VEC[v].isRead, int'(VEC[v].tile), int'(VEC[v].row), VEC[v].fill);
      chk($sformatf("R5 accErr vec %0d", v), 512'(accErr), 512'(VEC[v].expErr));
      if (VEC[v].isRead) begin
        chk($sformatf("R4 rdValid vec %0d", v), 512'(rdValid), 512'(!VEC[v].expErr));
        chk($sformatf("R6 rdData vec %0d", v), rdData,
            expRow(VEC[v].expByte, shapeCols(int'(VEC[v].tile))));
      end
    end

    // R3 rows above limit, then width above limit
    badRows = goodRows; badRows[2*ROW_W +: ROW_W] = ROW_W'(17);
    doCfg(8'd1, badRows, goodCols, 1'b0);
    chk("R3 rows 17 flagged", 512'(cfgErr), 512'(1));
    chk("R3 rows unchanged", 512'(tileRows), 512'(goodRows));
    badCols = goodCols; badCols[5*CB_W +: CB_W] = CB_W'(65);
    doCfg(8'd1, goodRows, badCols, 1'b0);
    chk("R3 cols 65 flagged", 512'(cfgErr), 512'(1));
    chk("R3 cols unchanged", 512'(tileColsb), 512'(goodCols));

    // R8 release clears contents
    doRelease();
    chk("R8 release unconfigures", 512'({configured, tileRows}), 512'(0));
    doCfg(8'd1, goodRows, goodCols, 1'b0);
    doAcc(1'b0, 0, 0, 8'h00);
    chk("R8 row zero after release", {rdData[510:0], rdValid}, 512'(1));

    // R8 palette 0 write clears
    doAcc(1'b1, 2, 3, 8'h5A);
    doCfg(8'd0, goodRows, goodCols, 1'b0);
    chk("R8 palette0 unconfigures", 512'({configured, cfgErr, tileColsb}), 512'(0));
    doCfg(8'd1, goodRows, goodCols, 1'b0);
    doAcc(1'b0, 2, 3, 8'h00);
    chk("R8 row zero after palette0", rdData, '0);

    // R9 release beats config write
    doCfg(8'd1, goodRows, goodCols, 1'b1);
    chk("R9 release wins over config", 512'({configured, cfgErr}), 512'(0));

    // R9 release beats access
    doCfg(8'd1, goodRows, goodCols, 1'b0);
    @(negedge clk);
    relCmd = 1'b1; accEn = 1'b1; accWe = 1'b0; accTile = '0; accRow = '0;
    @(negedge clk);
    relCmd = 1'b0; accEn = 1'b0;
    chk("R9 release wins over access", 512'({accErr, rdValid, configured}), 512'(3'b100));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule